// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This unit sits beside the execute stage of a 32-bit RISC-V core. It holds the machine-level control and status registers and carries out the three CSR access operations: swap, read-and-set and read-and-clear. Each operation returns the value the register held before the access. Every CSR address is decoded combinationally, so the prior value is on `csr_rdata` in the same cycle, and the new value lands on the next rising edge.

The unit also decides when the core must leave its instruction stream. Three interrupt request lines (external, timer and software) pass through a fixed-priority arbiter. The arbiter is gated by the global enable bit in the status register and by the per-source enable bits. An ecall strobe raises a synchronous trap. When a trap is taken, `trap_taken` and the handler address come out combinationally. On the following edge the unit records the cause, the return address and the interrupt stack bits. An mret strobe restores the interrupt enable, and `ret_pc` presents the saved return address at all times.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset, the status register (0x300) reads 0x00001800, the enable register (0x304) and the cause register (0x342) read 0, and the ISA register (0x301) reads 0x40000100.
- R2: Swap (`csr_op`=1) returns the prior value and writes the operand. Scratch (0x340), vector (0x305), cause (0x342) and trap value (0x343) take all 32 bits. The return-address register (0x341) forces bits 1:0 to zero. The enable register keeps only bits 11, 7 and 3. The status register keeps only bits 7 and 3.
- R3: Set (`csr_op`=2) ORs the operand into the register, and clear (`csr_op`=3) ANDs it with the inverted operand. Both return the prior value. `csr_op`=0 reads without writing.
- R4: Writes to the ISA register, the pending register (0x344) and the cycle counter are ignored. An unimplemented address reads 0 and ignores writes.
- R5: A 64-bit cycle counter increments on every clock. Its low half reads at 0xB00 and its high half at 0xB80. Two reads one cycle apart differ by 1.
- R6: No interrupt trap is taken while status bit 3 (global enable) is 0.
- R7: Enable-register bits 11, 7 and 3 enable the external, timer and software lines. A line with its enable bit clear is not taken. Pending-register bits 11, 7 and 3 show the lines as registered on the previous clock.
- R8: When several enabled lines are high, external wins over timer, and timer wins over software. The recorded causes are 0x8000000B, 0x80000007 and 0x80000003.
- R9: On a trap, `trap_taken` rises in the same cycle, and `trap_pc` equals the vector register with bits 1:0 cleared. After the edge, the return-address register holds `ex_pc` with bits 1:0 cleared, status bit 7 holds the old bit 3, bit 3 is 0, and the trap value register is 0.
- R10: An ecall traps with cause 0x0000000B. A qualifying interrupt in the same cycle takes precedence over the ecall.
- R11: `ret_pc` always equals the return-address register. On an mret, status bit 3 takes the old bit 7, and bit 7 becomes 1.
- R12: A CSR write in a cycle where a trap is taken is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 none, 1 swap, 2 set, 3 clear |
| csr_wdata | input | 32 | CSR operand |
| ex_pc | input | 32 | PC of the instruction in execute |
| irq_ext | input | 1 | External interrupt request |
| irq_tmr | input | 1 | Timer interrupt request |
| irq_sw | input | 1 | Software interrupt request |
| ecall_i | input | 1 | Environment call strobe |
| mret_i | input | 1 | Trap return strobe |
| csr_rdata | output | 32 | Prior value of the addressed CSR |
| trap_taken | output | 1 | A trap is taken this cycle |
| trap_pc | output | 32 | Handler address |
| ret_pc | output | 32 | Return address for mret |

## Verification
The read value, `trap_taken`, `trap_pc` and `ret_pc` are combinational and are due in the cycle of the stimulus. The bench samples them 2 ns after the falling edge on which it drives the inputs. Register updates (cause, return address, status bits, masked writes) are due one clock after the stimulus, and the pending register trails its lines by one clock. The bench therefore observes these through a read access made after the next rising edge. The cycle counter is checked by two reads placed exactly one clock apart.

// File: rtl/mcsr_pkg.sv
// Shared CSR addresses, operation encodings and cause codes for the trap unit.
package mcsr_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SWAP = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } csr_op_e;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_IEN     = 12'h304;
    localparam logic [11:0] A_TVEC    = 12'h305;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_IPEND   = 12'h344;
    localparam logic [11:0] A_CYC_LO  = 12'hB00;
    localparam logic [11:0] A_CYC_HI  = 12'hB80;

    localparam logic [31:0] ISA_VALUE   = 32'h4000_0100;
    localparam logic [31:0] CAUSE_EXT   = 32'h8000_000B;
    localparam logic [31:0] CAUSE_TMR   = 32'h8000_0007;
    localparam logic [31:0] CAUSE_SW    = 32'h8000_0003;
    localparam logic [31:0] CAUSE_ECALL = 32'h0000_000B;
endpackage

// File: rtl/csr_rmw_unit.sv
// Computes the new value of a CSR from its old value, the operand and the operation.
// Assumes the caller applies per-register write masks and decides whether to commit.
module csr_rmw_unit #(
    parameter int XLEN = 32
) (
    input  mcsr_pkg::csr_op_e op,
    input  logic [XLEN-1:0]   old_val,
    input  logic [XLEN-1:0]   operand,
    output logic [XLEN-1:0]   new_val,
    output logic              do_write
);
    import mcsr_pkg::*;

    // Select the read-modify-write result for the requested operation.
    always_comb begin
        do_write = (op != OP_NONE);
        unique case (op)
            OP_SWAP: new_val = operand;
            OP_SET:  new_val = old_val | operand;
            OP_CLR:  new_val = old_val & ~operand;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority interrupt selector: external over timer over software.
// Assumes request lines are already synchronous to the core clock.
module irq_arbiter (
    input  logic        gie,
    input  logic [2:0]  req,      // {ext, tmr, sw}
    input  logic [2:0]  en,       // {ext, tmr, sw}
    output logic        fire,
    output logic [31:0] cause
);
    import mcsr_pkg::*;

    logic [2:0] qual;

    // Qualify each line by its own enable and the global enable, then pick the winner.
    always_comb begin
        qual  = req & en & {3{gie}};
        fire  = |qual;
        cause = '0;
        if (qual[2])      cause = CAUSE_EXT;
        else if (qual[1]) cause = CAUSE_TMR;
        else if (qual[0]) cause = CAUSE_SW;
    end
endmodule

// File: rtl/mcsr_trap_unit.sv
// Machine-mode CSR file with trap entry and return.
// Assumes: one CSR access per cycle from execute; trap wins over a CSR write and
// over mret in the same cycle; the caller flushes the pipeline on trap_taken.
module mcsr_trap_unit #(
    parameter int          XLEN       = 32,
    parameter logic [31:0] RESET_TVEC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  csr_op,
    input  logic [31:0] csr_wdata,
    input  logic [31:0] ex_pc,
    input  logic        irq_ext,
    input  logic        irq_tmr,
    input  logic        irq_sw,
    input  logic        ecall_i,
    input  logic        mret_i,
    output logic [31:0] csr_rdata,
    output logic        trap_taken,
    output logic [31:0] trap_pc,
    output logic [31:0] ret_pc
);
    import mcsr_pkg::*;

    localparam int CNT_W = 2 * XLEN;

    logic             mie_b, mpie_b;
    logic [2:0]       ien_q;    // {ext, tmr, sw}
    logic [2:0]       ipend_q;  // {ext, tmr, sw}
    logic [XLEN-1:0]  tvec_q, scratch_q, epc_q, cause_q, tval_q;
    logic [CNT_W-1:0] cycle_q;

    logic [XLEN-1:0]  status_rd, ien_rd, ipend_rd, new_val;
    logic             rmw_wr, irq_fire, wr_en;
    logic [31:0]      irq_cause;
    csr_op_e          op_e;

    assign op_e = csr_op_e'(csr_op);

    // Pack the sparse status and interrupt bits into their architectural positions.
    always_comb begin
        status_rd     = 32'h0000_1800;
        status_rd[3]  = mie_b;
        status_rd[7]  = mpie_b;
        ien_rd        = '0;
        ien_rd[11]    = ien_q[2];
        ien_rd[7]     = ien_q[1];
        ien_rd[3]     = ien_q[0];
        ipend_rd      = '0;
        ipend_rd[11]  = ipend_q[2];
        ipend_rd[7]   = ipend_q[1];
        ipend_rd[3]   = ipend_q[0];
    end

    // Decode the CSR address into the prior value.
    always_comb begin
        unique case (csr_addr)
            A_STATUS:  csr_rdata = status_rd;
            A_ISA:     csr_rdata = ISA_VALUE;
            A_IEN:     csr_rdata = ien_rd;
            A_TVEC:    csr_rdata = tvec_q;
            A_SCRATCH: csr_rdata = scratch_q;
            A_EPC:     csr_rdata = epc_q;
            A_CAUSE:   csr_rdata = cause_q;
            A_TVAL:    csr_rdata = tval_q;
            A_IPEND:   csr_rdata = ipend_rd;
            A_CYC_LO:  csr_rdata = cycle_q[XLEN-1:0];
            A_CYC_HI:  csr_rdata = cycle_q[CNT_W-1:XLEN];
            default:   csr_rdata = '0;
        endcase
    end

    csr_rmw_unit #(.XLEN(XLEN)) u_rmw (
        .op       (op_e),
        .old_val  (csr_rdata),
        .operand  (csr_wdata),
        .new_val  (new_val),
        .do_write (rmw_wr)
    );

    irq_arbiter u_arb (
        .gie   (mie_b),
        .req   ({irq_ext, irq_tmr, irq_sw}),
        .en    (ien_q),
        .fire  (irq_fire),
        .cause (irq_cause)
    );

    assign trap_taken = irq_fire | ecall_i;
    assign trap_pc    = {tvec_q[XLEN-1:2], 2'b00};
    assign ret_pc     = epc_q;
    assign wr_en      = rmw_wr & ~trap_taken;

    // Free-running cycle counter and registered view of the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_q <= '0;
            ipend_q <= '0;
        end else begin
            cycle_q <= cycle_q + 1'b1;
            ipend_q <= {irq_ext, irq_tmr, irq_sw};
        end
    end

    // Status stack bits: trap entry, then mret, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mie_b  <= 1'b0;
            mpie_b <= 1'b0;
        end else if (trap_taken) begin
            mpie_b <= mie_b;
            mie_b  <= 1'b0;
        end else if (mret_i) begin
            mie_b  <= mpie_b;
            mpie_b <= 1'b1;
        end else if (wr_en && csr_addr == A_STATUS) begin
            mie_b  <= new_val[3];
            mpie_b <= new_val[7];
        end
    end

    // Trap record registers: written by hardware on a trap, else by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else if (trap_taken) begin
            epc_q   <= {ex_pc[XLEN-1:2], 2'b00};
            cause_q <= irq_fire ? irq_cause : CAUSE_ECALL;
            tval_q  <= '0;
        end else if (wr_en) begin
            if (csr_addr == A_EPC)   epc_q   <= {new_val[XLEN-1:2], 2'b00};
            if (csr_addr == A_CAUSE) cause_q <= new_val;
            if (csr_addr == A_TVAL)  tval_q  <= new_val;
        end
    end

    // Plain software-owned registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q     <= '0;
            tvec_q    <= RESET_TVEC;
            scratch_q <= '0;
        end else if (wr_en) begin
            if (csr_addr == A_IEN)     ien_q     <= {new_val[11], new_val[7], new_val[3]};
            if (csr_addr == A_TVEC)    tvec_q    <= new_val;
            if (csr_addr == A_SCRATCH) scratch_q <= new_val;
        end
    end
endmodule

// File: rtl/mcsr_trap_chk.sv
// Assertion checker for mcsr_trap_unit, attached by bind below.
// Assumes internal state names of the unit as connected in the bind.
module mcsr_trap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_taken,
    input logic        irq_fire,
    input logic        ecall_i,
    input logic        mret_i,
    input logic        irq_ext,
    input logic        en_ext,
    input logic [31:0] ex_pc,
    input logic        mie_b,
    input logic        mpie_b,
    input logic [31:0] epc_q,
    input logic [31:0] cause_q,
    input logic [63:0] cycle_q
);
    p_cycle_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_q == $past(cycle_q) + 64'd1);

    p_global_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mie_b && !ecall_i) |-> !trap_taken);

    p_prio_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && mie_b && irq_ext && en_ext) |=> cause_q == 32'h8000_000B);

    p_entry_epc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (epc_q == {$past(ex_pc[31:2]), 2'b00}) && !mie_b);

    p_entry_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> mpie_b == $past(mie_b));

    p_ecall_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ecall_i && !irq_fire) |=> cause_q == 32'h0000_000B);

    p_mret_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && !trap_taken) |=> (mie_b == $past(mpie_b)) && mpie_b);
endmodule

bind mcsr_trap_unit mcsr_trap_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_taken (trap_taken),
    .irq_fire   (irq_fire),
    .ecall_i    (ecall_i),
    .mret_i     (mret_i),
    .irq_ext    (irq_ext),
    .en_ext     (ien_q[2]),
    .ex_pc      (ex_pc),
    .mie_b      (mie_b),
    .mpie_b     (mpie_b),
    .epc_q      (epc_q),
    .cause_q    (cause_q),
    .cycle_q    (cycle_q)
);

// File: tb/mcsr_trap_unit_tb.sv
module mcsr_trap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] ex_pc = '0;
    logic        irq_ext = 0, irq_tmr = 0, irq_sw = 0, ecall_i = 0, mret_i = 0;
    logic [31:0] csr_rdata, trap_pc, ret_pc;
    logic        trap_taken;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rv, c0, c1;

    always #10 clk = ~clk;

    mcsr_trap_unit dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One CSR access: drive on falling edge, sample prior value, commit on rising edge.
    task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] old);
        @(negedge clk);
        csr_addr = a; csr_op = op; csr_wdata = d;
        #2 old = csr_rdata;
        @(posedge clk);
        #1 csr_op = 2'd0;
    endtask

    function automatic logic [31:0] rmw(input logic [1:0] op, input logic [31:0] o, input logic [31:0] d);
        case (op)
            2'd1: return d;
            2'd2: return o | d;
            2'd3: return o & ~d;
            default: return o;
        endcase
    endfunction

    function automatic logic [31:0] wmask(input logic [11:0] a);
        case (a)
            12'h304: return 32'h0000_0888;
            12'h341: return 32'hFFFF_FFFC;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Drive interrupt/ecall stimulus for one cycle and check the combinational trap outputs.
    task automatic pulse(input logic e, input logic t, input logic s, input logic ec,
                         input logic [31:0] pc, input logic exp_trap, input string req);
        @(negedge clk);
        irq_ext = e; irq_tmr = t; irq_sw = s; ecall_i = ec; ex_pc = pc;
        #2 chk(req, {31'b0, trap_taken}, {31'b0, exp_trap});
        @(posedge clk);
        #1 irq_ext = 0; irq_tmr = 0; irq_sw = 0; ecall_i = 0;
    endtask

    initial begin
        #4000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] regs [6];
        logic [31:0] model [6];
        void'($urandom(32'd20240611));
        regs = '{12'h340, 12'h304, 12'h305, 12'h342, 12'h343, 12'h341};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        acc(2'd0, 12'h300, 0, rv); chk("R1 status", rv, 32'h1800);
        acc(2'd0, 12'h304, 0, rv); chk("R1 ien", rv, 0);
        acc(2'd0, 12'h342, 0, rv); chk("R1 cause", rv, 0);
        acc(2'd0, 12'h301, 0, rv); chk("R1 isa", rv, 32'h4000_0100);

        // R2/R3 random read-modify-write against a model
        for (int i = 0; i < 6; i++) model[i] = 0;
        for (int i = 0; i < 300; i++) begin
            int k = $urandom_range(0, 5);
            logic [1:0] op = 2'($urandom_range(0, 3));
            logic [31:0] d = $urandom;
            acc(op, regs[k], d, rv);
            chk(op == 2'd1 ? "R2 swap" : "R3 set/clear", rv, model[k]);
            model[k] = rmw(op, model[k], d) & wmask(regs[k]);
        end
        for (int k = 0; k < 6; k++) begin
            acc(2'd0, regs[k], 0, rv); chk("R2 final", rv, model[k]);
        end
        // R2 status keeps only bits 7 and 3
        acc(2'd1, 12'h300, 32'hFFFF_FFFF, rv);
        acc(2'd3, 12'h300, 32'hFFFF_FFFF, rv); chk("R2 status mask", rv, 32'h1888);
        acc(2'd0, 12'h300, 0, rv); chk("R3 status clear", rv, 32'h1800);

        // R4 read-only and unimplemented
        acc(2'd1, 12'h301, 32'h0, rv);
        acc(2'd0, 12'h301, 0, rv); chk("R4 isa ro", rv, 32'h4000_0100);
        acc(2'd1, 12'h344, 32'hFFFF_FFFF, rv);
        acc(2'd0, 12'h344, 0, rv); chk("R4 ipend ro", rv, 0);
        acc(2'd1, 12'h7C0, 32'h1234_5678, rv); chk("R4 unimpl", rv, 0);
        acc(2'd0, 12'h7C0, 0, rv); chk("R4 unimpl after", rv, 0);
        acc(2'd1, 12'hB80, 32'hFFFF_FFFF, rv);
        acc(2'd0, 12'hB80, 0, rv); chk("R4 cycle hi ro", rv, 0);

        // R5 cycle counter
        acc(2'd0, 12'hB00, 0, c0);
        acc(2'd0, 12'hB00, 0, c1); chk("R5 step", c1 - c0, 1);

        // Set up vector and enables
        acc(2'd1, 12'h305, 32'h0000_1003, rv);
        acc(2'd1, 12'h304, 32'h0000_0888, rv);

        // R6 gate: global enable off
        pulse(1, 1, 1, 0, 32'h500, 0, "R6 gated");
        // R7 pending reflects registered lines
        @(negedge clk); irq_tmr = 1;
        @(posedge clk);
        acc(2'd0, 12'h344, 0, rv); chk("R7 pending", rv, 32'h80);
        #1 irq_tmr = 0;

        // R8/R9 external + timer, external wins
        acc(2'd2, 12'h300, 32'h8, rv);
        @(negedge clk);
        irq_ext = 1; irq_tmr = 1; ex_pc = 32'h0000_0402;
        #2 chk("R9 trap", {31'b0, trap_taken}, 1);
        chk("R9 trap_pc", trap_pc, 32'h1000);
        @(posedge clk); #1 irq_ext = 0; irq_tmr = 0;
        acc(2'd0, 12'h342, 0, rv); chk("R8 ext cause", rv, 32'h8000_000B);
        acc(2'd0, 12'h341, 0, rv); chk("R9 epc", rv, 32'h400);
        acc(2'd0, 12'h300, 0, rv); chk("R9 stack", rv, 32'h1880);
        acc(2'd0, 12'h343, 0, rv); chk("R9 tval", rv, 0);

        // R11 mret
        @(negedge clk); mret_i = 1;
        #2 chk("R11 ret_pc", ret_pc, 32'h400);
        @(posedge clk); #1 mret_i = 0;
        acc(2'd0, 12'h300, 0, rv); chk("R11 restore", rv, 32'h1888);

        // R8 timer over software
        pulse(0, 1, 1, 0, 32'h600, 1, "R8 tmr trap");
        acc(2'd0, 12'h342, 0, rv); chk("R8 tmr cause", rv, 32'h8000_0007);
        acc(2'd2, 12'h300, 32'h8, rv);
        pulse(0, 0, 1, 0, 32'h604, 1, "R8 sw trap");
        acc(2'd0, 12'h342, 0, rv); chk("R8 sw cause", rv, 32'h8000_0003);

        // R7 per-source enable
        acc(2'd3, 12'h304, 32'h800, rv);
        acc(2'd2, 12'h300, 32'h8, rv);
        pulse(1, 0, 0, 0, 32'h700, 0, "R7 ext disabled");

        // R10 ecall alone, then ecall with interrupt
        pulse(0, 0, 0, 1, 32'h800, 1, "R10 ecall trap");
        acc(2'd0, 12'h342, 0, rv); chk("R10 ecall cause", rv, 32'h0000_000B);
        acc(2'd0, 12'h341, 0, rv); chk("R10 ecall epc", rv, 32'h800);
        acc(2'd2, 12'h300, 32'h8, rv);
        pulse(0, 0, 1, 1, 32'h900, 1, "R10 both");
        acc(2'd0, 12'h342, 0, rv); chk("R10 irq over ecall", rv, 32'h8000_0003);

        // R12 CSR write discarded on trap
        acc(2'd1, 12'h340, 32'hAAAA_5555, rv);
        acc(2'd2, 12'h300, 32'h8, rv);
        @(negedge clk);
        irq_sw = 1; csr_addr = 12'h340; csr_op = 2'd1; csr_wdata = 32'h0BAD_F00D;
        #2 chk("R12 trap", {31'b0, trap_taken}, 1);
        @(posedge clk); #1 irq_sw = 0; csr_op = 2'd0;
        acc(2'd0, 12'h340, 0, rv); chk("R12 no write", rv, 32'hAAAA_5555);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule